// File: doc/BRIEF.md
# Level-Priority Interrupt Selector

The block gathers level-sensitive interrupt requests from a set of on-chip sources and from a 4-bit encoded external level input, and hands the CPU one winning request at a time. Each on-chip source belongs to a group. Each group takes a 4-bit priority from a packed field in one of several 16-bit priority registers. A 32-bit mask, written through separate set and clear addresses, can block single on-chip sources.

On every clock the block chooses, among the eligible requests, the one with the highest priority. It registers that request's event code together with a request flag. A request is eligible when it is pending, unmasked, and has a priority strictly above the interrupt level that the CPU supplies. Software writes the configuration through a simple write port. The CPU samples `irq_req` and `irq_code`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every priority field is 0 and every mask bit is clear, so no request is presented: `irq_req` = 0 and `irq_code` = 0, even when every on-chip source is pending.
- R2: A write to address k (k < NUM_PRIO_REGS) loads `wr_data[15:0]` into priority register k. Bits [4j+3:4j] of register k set the priority of group 4k+j. Group g covers on-chip sources g*SRC_PER_GRP through g*SRC_PER_GRP+SRC_PER_GRP-1, and all of them share that priority. With no write, the priority registers hold their values.
- R3: A source whose group priority is 0 is never presented.
- R4: A write to address NUM_PRIO_REGS sets every mask bit where `wr_data` has a 1 and leaves the other bits unchanged. Mask bit i set blocks on-chip source i.
- R5: A write to address NUM_PRIO_REGS+1 clears every mask bit where `wr_data` has a 1 and leaves the other bits unchanged.
- R6: Among eligible requests, the highest priority wins. On a tie the lowest index wins, and the external request counts as index NUM_SRC.
- R7: On-chip source i has event code 0x400 + 0x20*i.
- R8: An external level n in 0..14 has event code 0x200 + 0x20*n and priority 15-n. It is not affected by the mask. Level 0xF means no external request.
- R9: A request is eligible only when its priority is strictly greater than `cpu_imask`.
- R10: `irq_req` and `irq_code` are registered, so they show the selection made from the inputs and register state present at the previous clock edge. `irq_code` is 0 whenever `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | $clog2(NUM_PRIO_REGS+2) | Write address: priority registers, then mask-set, then mask-clear |
| wr_data | input | 32 | Write data |
| src_req | input | NUM_PRIO_REGS*4*SRC_PER_GRP | Level requests from the on-chip sources |
| ext_lvl | input | 4 | Encoded external request level, 0xF = none |
| cpu_imask | input | 4 | CPU interrupt level; only higher priorities are presented |
| irq_req | output | 1 | A request is presented |
| irq_code | output | 12 | Event code of the presented request |

## Verification
The bench uses the default build: two priority registers and four sources per group, which gives 8 groups and 32 on-chip sources, so every bit of the 32-bit mask maps to a source. With this size the bench can walk every source through all 16 priority values, sweep every CPU level against every external level, and compare the result with an arithmetic model of the codes and priorities. It also checks tie-breaking and mask set/clear patterns on fully loaded request vectors.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int CODE_W = 12;
  localparam int PRIO_W = 4;

  // R7: on-chip source event code
  function automatic logic [CODE_W-1:0] src_code(input int idx);
    return CODE_W'(32'h400 + 32'(idx) * 32'h20);
  endfunction

  // R8: external level event code
  function automatic logic [CODE_W-1:0] ext_code(input logic [3:0] lvl);
    return CODE_W'(32'h200 + 32'(lvl) * 32'h20);
  endfunction

  // R8: external level priority, 0xF yields 0 (no request)
  function automatic logic [PRIO_W-1:0] ext_prio(input logic [3:0] lvl);
    return 4'hF - lvl;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NPR   = 2,
  parameter int NSRC  = 32,
  parameter int AW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [31:0]       wr_data,
  output logic [NPR*16-1:0] prio_flat,
  output logic [NSRC-1:0]   mask
);
  localparam int SET_ADDR = NPR;
  localparam int CLR_ADDR = NPR + 1;

  logic set_hit, clr_hit;
  assign set_hit = wr_en && (int'(wr_addr) == SET_ADDR);
  assign clr_hit = wr_en && (int'(wr_addr) == CLR_ADDR);

  for (genvar k = 0; k < NPR; k++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prio_flat[k*16 +: 16] <= '0;
      else if (wr_en && int'(wr_addr) == k)
        prio_flat[k*16 +: 16] <= wr_data[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask <= '0;
    else if (set_hit)
      mask <= mask | wr_data[NSRC-1:0];
    else if (clr_hit)
      mask <= mask & ~wr_data[NSRC-1:0];
  end

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((mask & $past(wr_data[NSRC-1:0])) == $past(wr_data[NSRC-1:0])));

  // R5
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((mask & $past(wr_data[NSRC-1:0])) == '0));

  // R2
  prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(prio_flat));
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_sel_pkg::*;
#(
  parameter int NPR  = 2,
  parameter int SPG  = 4,
  parameter int NSRC = NPR * 4 * SPG
) (
  input  logic [NPR*16-1:0]  prio_flat,
  input  logic [NSRC-1:0]    mask,
  input  logic [NSRC-1:0]    src_req,
  input  logic [3:0]         ext_lvl,
  input  logic [3:0]         cpu_imask,
  output logic               win_valid,
  output logic [PRIO_W-1:0]  win_prio,
  output logic [CODE_W-1:0]  win_code
);
  logic [PRIO_W-1:0] src_prio [NSRC];
  logic [NSRC-1:0]   src_elig;

  // R2: source i takes the field of its group
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign src_prio[i] = prio_flat[(i / SPG) * 4 +: 4];
    assign src_elig[i] = src_req[i] && !mask[i] && (src_prio[i] > cpu_imask);
  end

  logic [PRIO_W-1:0] xp;
  assign xp = ext_prio(ext_lvl);

  // R6: strict compare keeps the lowest index on ties
  always_comb begin
    win_valid = 1'b0;
    win_prio  = '0;
    win_code  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_elig[i] && (src_prio[i] > win_prio)) begin
        win_valid = 1'b1;
        win_prio  = src_prio[i];
        win_code  = src_code(i);
      end
    end
    if ((xp > cpu_imask) && (xp > win_prio)) begin
      win_valid = 1'b1;
      win_prio  = xp;
      win_code  = ext_code(ext_lvl);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_sel_pkg::*;
#(
  parameter int NUM_PRIO_REGS = 2,
  parameter int SRC_PER_GRP   = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    wr_en,
  input  logic [$clog2(NUM_PRIO_REGS+2)-1:0]      wr_addr,
  input  logic [31:0]                             wr_data,
  input  logic [NUM_PRIO_REGS*4*SRC_PER_GRP-1:0]  src_req,
  input  logic [3:0]                              ext_lvl,
  input  logic [3:0]                              cpu_imask,
  output logic                                    irq_req,
  output logic [11:0]                             irq_code
);
  localparam int NSRC = NUM_PRIO_REGS * 4 * SRC_PER_GRP;
  localparam int AW   = $clog2(NUM_PRIO_REGS + 2);

  logic [NUM_PRIO_REGS*16-1:0] prio_flat;
  logic [NSRC-1:0]             mask;
  logic                        win_valid;
  logic [PRIO_W-1:0]           win_prio;
  logic [CODE_W-1:0]           win_code;

  irq_cfg_regs #(.NPR(NUM_PRIO_REGS), .NSRC(NSRC), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .prio_flat (prio_flat),
    .mask      (mask)
  );

  irq_pick #(.NPR(NUM_PRIO_REGS), .SPG(SRC_PER_GRP), .NSRC(NSRC)) u_pick (
    .prio_flat (prio_flat),
    .mask      (mask),
    .src_req   (src_req),
    .ext_lvl   (ext_lvl),
    .cpu_imask (cpu_imask),
    .win_valid (win_valid),
    .win_prio  (win_prio),
    .win_code  (win_code)
  );

  // R10: registered outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req  <= 1'b0;
      irq_code <= '0;
    end else begin
      irq_req  <= win_valid;
      irq_code <= win_valid ? win_code : '0;
    end
  end

  // R9
  prio_above_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_prio > cpu_imask));

  // R3
  zero_prio_never_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_prio != '0));

  // R10
  idle_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_code == '0));

  // R8
  quiet_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_lvl == 4'hF && src_req == '0) |=> !irq_req);
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int NPR  = 2;
  localparam int SPG  = 4;
  localparam int NSRC = NPR * 4 * SPG;
  localparam int NGRP = NPR * 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NSRC-1:0] src_req = '0;
  logic [3:0]  ext_lvl = 4'hF;
  logic [3:0]  cpu_imask = '0;
  logic        irq_req;
  logic [11:0] irq_code;

  int errors = 0;
  int checks = 0;
  logic [3:0]  fld [NGRP];
  logic [31:0] sh_mask = '0;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.NUM_PRIO_REGS(NPR), .SRC_PER_GRP(SPG)) i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .src_req(src_req), .ext_lvl(ext_lvl),
    .cpu_imask(cpu_imask), .irq_req(irq_req), .irq_code(irq_code)
  );

  task automatic model(output logic req, output logic [11:0] code);
    int best = 0;
    req = 1'b0; code = '0;
    for (int i = 0; i < NSRC; i++) begin
      int p = int'(fld[i / SPG]);
      if (src_req[i] && !sh_mask[i] && p > int'(cpu_imask) && p > best) begin
        best = p; req = 1'b1; code = 12'(1024 + 32 * i);
      end
    end
    if (ext_lvl != 4'hF) begin
      int p = 15 - int'(ext_lvl);
      if (p > int'(cpu_imask) && p > best) begin
        req = 1'b1; code = 12'(512 + 32 * int'(ext_lvl));
      end
    end
  endtask

  task automatic check(input string tag);
    logic er; logic [11:0] ec;
    @(posedge clk); @(negedge clk);
    model(er, ec);
    checks++;
    if (irq_req !== er || irq_code !== ec) begin
      errors++;
      $display("FAIL %s: req=%0b code=%h expected req=%0b code=%h", tag, irq_req, irq_code, er, ec);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < NPR) for (int j = 0; j < 4; j++) fld[a*4+j] = d[j*4 +: 4];
    else if (a == NPR) sh_mask = sh_mask | d;
    else sh_mask = sh_mask & ~d;
  endtask

  task automatic set_all_fields(input logic [3:0] v [NGRP]);
    for (int k = 0; k < NPR; k++)
      wr(k, {16'h0, v[k*4+3], v[k*4+2], v[k*4+1], v[k*4]});
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] v [NGRP];
    logic [31:0] lf;
    for (int g = 0; g < NGRP; g++) fld[g] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, everything pending
    src_req = '1; ext_lvl = 4'hF;
    check("R1");

    // R2 R3 R7: each source alone through every priority
    for (int i = 0; i < NSRC; i++) begin
      src_req = '0; src_req[i] = 1'b1;
      for (int p = 0; p < 16; p++) begin
        for (int g = 0; g < NGRP; g++) v[g] = (g == i / SPG) ? 4'(p) : 4'h0;
        set_all_fields(v);
        check(p == 0 ? "R3" : "R7");
      end
    end

    // R9: level sweep against one source
    src_req = '0; src_req[5] = 1'b1;
    for (int g = 0; g < NGRP; g++) v[g] = 4'(g + 7);
    set_all_fields(v);
    for (int m = 0; m < 16; m++) begin cpu_imask = 4'(m); check("R9"); end
    cpu_imask = '0;

    // R8: external levels against every CPU level
    src_req = '0;
    for (int l = 0; l < 16; l++)
      for (int m = 0; m < 16; m++) begin
        ext_lvl = 4'(l); cpu_imask = 4'(m); check("R8");
      end
    cpu_imask = '0;

    // R6: tie among all groups, then distinct priorities, pseudo-random patterns
    for (int g = 0; g < NGRP; g++) v[g] = 4'h6;
    set_all_fields(v);
    ext_lvl = 4'd9; // external priority 6, ties with everything
    lf = 32'hACE1_2345;
    for (int t = 0; t < 40; t++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      src_req = lf; check("R6");
    end
    for (int g = 0; g < NGRP; g++) v[g] = 4'((g * 5 + 3) % 16);
    set_all_fields(v);
    for (int t = 0; t < 40; t++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      src_req = lf; ext_lvl = lf[3:0]; check("R6");
    end

    // R4 R5: mask set/clear with everything pending, equal priorities
    ext_lvl = 4'hF; src_req = '1;
    for (int g = 0; g < NGRP; g++) v[g] = 4'h4;
    set_all_fields(v);
    for (int b = 0; b < NSRC; b++) begin
      wr(NPR, 32'h1 << b); check("R4");
    end
    for (int b = NSRC - 1; b >= 0; b--) begin
      wr(NPR + 1, 32'h1 << b); check("R5");
      if (b > 0) begin wr(NPR, 32'h1 << b); end
    end
    wr(NPR, 32'hF0F0_F0F0); check("R4");
    wr(NPR + 1, 32'h00F0_0000); check("R5");
    wr(NPR + 1, 32'h0000_0000); check("R5");
    wr(NPR, 32'hFFFF_FFFF); check("R4");
    ext_lvl = 4'd12; check("R8");
    wr(NPR + 1, 32'hFFFF_FFFF); check("R5");

    // R10: output follows input change one edge later
    src_req = '0; ext_lvl = 4'hF; check("R10");
    src_req[31] = 1'b1; check("R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule